// File: doc/BRIEF.md
# Two-Level Interrupt Flag Aggregator

This block collects interrupt flags from a set of peripheral sources and turns them into interrupt requests for a processor core. Each source owns a small bank of flags. A flag is raised by its hardware event, can be raised or lowered by software through separate write-ones ports, and is qualified by a per-flag enable mask. The qualified flags of every source mapped to the same line are OR-reduced into one per-line IRQ.

The second level sits on the core side. A high IRQ line latches a per-line pending bit. Software can set or clear that bit, and an acknowledge input can also clear it. A pending bit becomes a core request only while the line's enable bit is set, and that enable is changed through its own set and clear controls. The number of sources, flags per source and lines, and the source-to-line map, are parameters. Up to 21 lines are allowed, and several sources may share one line.

Top module: `irq_flag_aggregator`

## Requirements
- R1: After reset all flags, flag enables, pending bits and line enables read 0, and the IRQ and core request outputs are 0.
- R2: A bit set in `hw_evt` sets the matching flag at the next clock edge, even when `sw_flag_clr` asks to clear the same bit in that cycle.
- R3: A 1 in `sw_flag_set` sets the matching flag at the next edge, and this set wins over a clear of the same bit in the same cycle. A flag with no event, set or clear keeps its value.
- R4: A 1 in `sw_flag_clr` clears the matching flag at the next edge unless a hardware event or a software set hits that bit in the same cycle. A 0 bit in either software port leaves the flag unchanged.
- R5: When `flag_en_wr[m]` is 1, the enable mask of source m (bits m*FLAG_W and up of `flag_en`) is loaded from `flag_en_data` at the next edge. A flag raises its line only while its enable bit is 1, and flags are stored whether or not they are enabled.
- R6: `src_irq[l]` is 1 when any enabled flag of any source mapped to line l is 1. The default map sends source 0 to line 0, sources 1 and 2 to line 1, and source 3 to line 2.
- R7: A line whose `src_irq` is high, or whose `pend_set` bit is 1, has its pending bit set at the next edge.
- R8: A pending bit stays set after its IRQ falls. It clears at the next edge when `pend_clr` or `irq_ack` is 1 for that line, and the clear wins over a set in that cycle. If the IRQ is still high, the bit is set again one edge later.
- R9: `line_en_set` sets and `line_en_clr` clears a line enable at the next edge, and the clear wins when both are 1.
- R10: `core_req[l]` is 1 exactly when both the pending bit and the enable of line l are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_evt | input | N_SRC*FLAG_W | Hardware interrupt conditions, one per flag |
| sw_flag_set | input | N_SRC*FLAG_W | Write-ones-to-set for flags |
| sw_flag_clr | input | N_SRC*FLAG_W | Write-ones-to-clear for flags |
| flag_en_wr | input | N_SRC | Load strobe for each source's enable mask |
| flag_en_data | input | N_SRC*FLAG_W | New enable mask values |
| pend_set | input | N_LINES | Software set of pending bits |
| pend_clr | input | N_LINES | Software clear of pending bits |
| irq_ack | input | N_LINES | Acknowledge clear of pending bits |
| line_en_set | input | N_LINES | Set of line enables |
| line_en_clr | input | N_LINES | Clear of line enables |
| flags | output | N_SRC*FLAG_W | Stored flag values |
| flag_en | output | N_SRC*FLAG_W | Stored flag enable masks |
| src_irq | output | N_LINES | Per-line OR of enabled flags |
| pending | output | N_LINES | Core-side pending bits |
| line_en | output | N_LINES | Core-side line enables |
| core_req | output | N_LINES | Final requests to the core |

## Verification
The embedded assertions check on every cycle that hardware events always land in the flags, that a clear without a competing set empties a flag, that untouched flags hold, that a high line or software set leaves its pending bit set unless cleared, that pending bits hold without a clear, and that a line enable clear always takes effect. The scenarios are needed to show what no single-cycle property captures. These include the routing of two sources onto a shared line, the way masking hides stored flags, the re-arming of a pending bit one edge after it is cleared while the line stays high, and the exact timing of `core_req` against pending and enable changes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Upper bound on the number of request lines the core side accepts.
   localparam int unsigned IRQ_MAX_LINES = 21;

   // Width of one entry in the source-to-line map parameter.
   localparam int unsigned IRQ_MAP_FIELD_W = 8;

   typedef logic [IRQ_MAP_FIELD_W-1:0] irq_line_idx_t;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned FLAG_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] hw_evt,
   input  logic [FLAG_W-1:0] sw_set,
   input  logic [FLAG_W-1:0] sw_clr,
   input  logic              en_wr,
   input  logic [FLAG_W-1:0] en_data,
   output logic [FLAG_W-1:0] flag_q,
   output logic [FLAG_W-1:0] en_q,
   output logic              src_req
);

   initial begin
      if (FLAG_W < 1) $error("irq_flag_bank: FLAG_W must be at least 1");
   end

   logic [FLAG_W-1:0] set_any;
   logic [FLAG_W-1:0] flag_d;

   // Any set source beats a clear of the same bit.
   assign set_any = hw_evt | sw_set;
   assign flag_d  = (flag_q & ~sw_clr) | set_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= flag_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_wr) begin
         en_q <= en_data;
      end
   end

   assign src_req = |(flag_q & en_q);

   // R2
   hw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & $past(hw_evt)) == $past(hw_evt)));

   // R4
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & $past(sw_clr & ~hw_evt & ~sw_set)) == '0));

   // R3
   idle_flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((flag_q ^ $past(flag_q)) & ~$past(hw_evt | sw_set | sw_clr)) == '0));

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
   import irq_agg_pkg::*;
#(
   parameter int unsigned N_SRC   = 4,
   parameter int unsigned N_LINES = 3,
   parameter logic [N_SRC*IRQ_MAP_FIELD_W-1:0] SRC_LINE = '0
) (
   input  logic [N_SRC-1:0]   src_req,
   output logic [N_LINES-1:0] line_req
);

   for (genvar l = 0; l < N_LINES; l++) begin : g_line
      logic acc;
      always_comb begin
         acc = 1'b0;
         for (int m = 0; m < N_SRC; m++) begin
            if (irq_line_idx_t'(SRC_LINE[m*IRQ_MAP_FIELD_W +: IRQ_MAP_FIELD_W])
                == irq_line_idx_t'(l)) begin
               acc = acc | src_req[m];
            end
         end
      end
      assign line_req[l] = acc;
   end

endmodule

// File: rtl/irq_core_stage.sv
module irq_core_stage #(
   parameter int unsigned N_LINES = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] line_irq,
   input  logic [N_LINES-1:0] pend_set,
   input  logic [N_LINES-1:0] pend_clr,
   input  logic [N_LINES-1:0] irq_ack,
   input  logic [N_LINES-1:0] en_set,
   input  logic [N_LINES-1:0] en_clr,
   output logic [N_LINES-1:0] pend_q,
   output logic [N_LINES-1:0] en_q,
   output logic [N_LINES-1:0] req
);

   logic [N_LINES-1:0] pend_kill;
   logic [N_LINES-1:0] pend_d;
   logic [N_LINES-1:0] en_d;

   // A clear wins in its own cycle; a line that stays high re-arms later.
   assign pend_kill = pend_clr | irq_ack;
   assign pend_d    = (pend_q | pend_set | line_irq) & ~pend_kill;
   assign en_d      = (en_q | en_set) & ~en_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
      end else begin
         pend_q <= pend_d;
         en_q   <= en_d;
      end
   end

   assign req = pend_q & en_q;

   // R7
   pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~pend_q & $past((line_irq | pend_set) & ~(pend_clr | irq_ack))) == '0));

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~pend_q & $past(pend_q & ~(pend_clr | irq_ack))) == '0));

   // R9
   en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((en_q & $past(en_clr)) == '0));

endmodule

// File: rtl/irq_flag_aggregator.sv
module irq_flag_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned N_SRC   = 4,
   parameter int unsigned FLAG_W  = 4,
   parameter int unsigned N_LINES = 3,
   parameter logic [N_SRC*IRQ_MAP_FIELD_W-1:0] SRC_LINE = 32'h0201_0100
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_SRC*FLAG_W-1:0]   hw_evt,
   input  logic [N_SRC*FLAG_W-1:0]   sw_flag_set,
   input  logic [N_SRC*FLAG_W-1:0]   sw_flag_clr,
   input  logic [N_SRC-1:0]          flag_en_wr,
   input  logic [N_SRC*FLAG_W-1:0]   flag_en_data,
   input  logic [N_LINES-1:0]        pend_set,
   input  logic [N_LINES-1:0]        pend_clr,
   input  logic [N_LINES-1:0]        irq_ack,
   input  logic [N_LINES-1:0]        line_en_set,
   input  logic [N_LINES-1:0]        line_en_clr,
   output logic [N_SRC*FLAG_W-1:0]   flags,
   output logic [N_SRC*FLAG_W-1:0]   flag_en,
   output logic [N_LINES-1:0]        src_irq,
   output logic [N_LINES-1:0]        pending,
   output logic [N_LINES-1:0]        line_en,
   output logic [N_LINES-1:0]        core_req
);

   localparam int unsigned TOTAL_FLAGS = N_SRC * FLAG_W;

   // Elaboration-time parameter checks.
   if (N_SRC < 1) begin : g_bad_src
      $error("irq_flag_aggregator: N_SRC must be at least 1");
   end
   if (N_LINES < 1 || N_LINES > IRQ_MAX_LINES) begin : g_bad_lines
      $error("irq_flag_aggregator: N_LINES out of range");
   end
   for (genvar m = 0; m < N_SRC; m++) begin : g_map_chk
      if (SRC_LINE[m*IRQ_MAP_FIELD_W +: IRQ_MAP_FIELD_W] >= N_LINES) begin : g_bad_map
         $error("irq_flag_aggregator: source mapped past last line");
      end
   end

   logic [N_SRC-1:0]       src_req;
   logic [TOTAL_FLAGS-1:0] flag_vec;
   logic [TOTAL_FLAGS-1:0] en_vec;

   for (genvar m = 0; m < N_SRC; m++) begin : g_src
      irq_flag_bank #(
         .FLAG_W (FLAG_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .hw_evt  (hw_evt      [m*FLAG_W +: FLAG_W]),
         .sw_set  (sw_flag_set [m*FLAG_W +: FLAG_W]),
         .sw_clr  (sw_flag_clr [m*FLAG_W +: FLAG_W]),
         .en_wr   (flag_en_wr  [m]),
         .en_data (flag_en_data[m*FLAG_W +: FLAG_W]),
         .flag_q  (flag_vec    [m*FLAG_W +: FLAG_W]),
         .en_q    (en_vec      [m*FLAG_W +: FLAG_W]),
         .src_req (src_req     [m])
      );
   end

   irq_line_merge #(
      .N_SRC    (N_SRC),
      .N_LINES  (N_LINES),
      .SRC_LINE (SRC_LINE)
   ) u_merge (
      .src_req  (src_req),
      .line_req (src_irq)
   );

   irq_core_stage #(
      .N_LINES (N_LINES)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_irq (src_irq),
      .pend_set (pend_set),
      .pend_clr (pend_clr),
      .irq_ack  (irq_ack),
      .en_set   (line_en_set),
      .en_clr   (line_en_clr),
      .pend_q   (pending),
      .en_q     (line_en),
      .req      (core_req)
   );

   assign flags   = flag_vec;
   assign flag_en = en_vec;

   // R5
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_wr[0]) |=> (flag_en[FLAG_W-1:0] == $past(flag_en_data[FLAG_W-1:0])));

   // R10
   req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((core_req & ~line_en) == '0));

endmodule

// File: tb/tb_irq_flag_aggregator.sv
module tb_irq_flag_aggregator;

   localparam int NS = 4;
   localparam int FW = 4;
   localparam int NL = 3;
   localparam int TF = NS * FW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [TF-1:0] hw_evt, sw_flag_set, sw_flag_clr, flag_en_data;
   logic [NS-1:0] flag_en_wr;
   logic [NL-1:0] pend_set, pend_clr, irq_ack, line_en_set, line_en_clr;
   logic [TF-1:0] flags, flag_en;
   logic [NL-1:0] src_irq, pending, line_en, core_req;

   irq_flag_aggregator dut (
      .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .sw_flag_set(sw_flag_set),
      .sw_flag_clr(sw_flag_clr), .flag_en_wr(flag_en_wr), .flag_en_data(flag_en_data),
      .pend_set(pend_set), .pend_clr(pend_clr), .irq_ack(irq_ack),
      .line_en_set(line_en_set), .line_en_clr(line_en_clr), .flags(flags),
      .flag_en(flag_en), .src_irq(src_irq), .pending(pending), .line_en(line_en),
      .core_req(core_req)
   );

   typedef struct {
      string         tag;
      logic [TF-1:0] f;
      logic [TF-1:0] e;
      logic [NL-1:0] irq;
      logic [NL-1:0] pnd;
      logic [NL-1:0] len;
      logic [NL-1:0] req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 0;

   logic [TF-1:0] m_f = '0, m_e = '0;
   logic [NL-1:0] m_p = '0, m_l = '0;

   // Line map from R6: source 0 -> line 0, sources 1,2 -> line 1, source 3 -> line 2.
   function automatic logic [NL-1:0] lines_of(input logic [TF-1:0] f, input logic [TF-1:0] e);
      logic [TF-1:0] q;
      q = f & e;
      lines_of[0] = |q[3:0];
      lines_of[1] = (|q[7:4]) | (|q[11:8]);
      lines_of[2] = |q[15:12];
   endfunction

   task automatic drive(input string t,
                        input logic [TF-1:0] hw = '0, input logic [TF-1:0] ss = '0,
                        input logic [TF-1:0] sc = '0, input logic [NS-1:0] ew = '0,
                        input logic [TF-1:0] ed = '0, input logic [NL-1:0] ps = '0,
                        input logic [NL-1:0] pc = '0, input logic [NL-1:0] ak = '0,
                        input logic [NL-1:0] ls = '0, input logic [NL-1:0] lc = '0);
      exp_t          it;
      logic [NL-1:0] irq_now;
      @(negedge clk);
      hw_evt = hw; sw_flag_set = ss; sw_flag_clr = sc; flag_en_wr = ew;
      flag_en_data = ed; pend_set = ps; pend_clr = pc; irq_ack = ak;
      line_en_set = ls; line_en_clr = lc;
      irq_now = lines_of(m_f, m_e);
      m_f = (m_f & ~sc) | hw | ss;
      for (int m = 0; m < NS; m++) if (ew[m]) m_e[m*FW +: FW] = ed[m*FW +: FW];
      m_p = (m_p | ps | irq_now) & ~(pc | ak);
      m_l = (m_l | ls) & ~lc;
      it.tag = t; it.f = m_f; it.e = m_e; it.irq = lines_of(m_f, m_e);
      it.pnd = m_p; it.len = m_l; it.req = m_p & m_l;
      exp_q.push_back(it);
   endtask

   // Monitor: compares each cycle's outputs against the scoreboard head.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (flags !== it.f || flag_en !== it.e || src_irq !== it.irq ||
                pending !== it.pnd || line_en !== it.len || core_req !== it.req) begin
               n_bad++;
               $display("FAIL %s: got f=%h e=%h irq=%b p=%b en=%b req=%b exp f=%h e=%h irq=%b p=%b en=%b req=%b",
                        it.tag, flags, flag_en, src_irq, pending, line_en, core_req,
                        it.f, it.e, it.irq, it.pnd, it.len, it.req);
            end
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      hw_evt = '0; sw_flag_set = '0; sw_flag_clr = '0; flag_en_wr = '0; flag_en_data = '0;
      pend_set = '0; pend_clr = '0; irq_ack = '0; line_en_set = '0; line_en_clr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      n_chk++;
      if ({flags, flag_en, src_irq, pending, line_en, core_req} !== '0) begin
         n_bad++;
         $display("FAIL R1: got f=%h e=%h p=%b en=%b expected all zero", flags, flag_en, pending, line_en);
      end

      // R2 flag set while masked: stored, line stays low (R5)
      drive(.t("R2"), .hw(16'h0002));
      drive(.t("R5 masked"));
      // R5 unmask source 0 bit 1: line 0 rises after load
      drive(.t("R5"), .ew(4'b0001), .ed(16'h0002));
      // R7 pending follows the high line one edge later
      drive(.t("R7"));
      // R9 / R10 enable line 0, request appears
      drive(.t("R9"), .ls(3'b001));
      drive(.t("R10"));
      // R4 software clear drops flag; R8 pending holds
      drive(.t("R4"), .sc(16'h0002));
      drive(.t("R8 hold"));
      drive(.t("R8 clr"), .pc(3'b001));
      // R4 zero bits in clear port have no effect, R3 set port
      drive(.t("R3"), .ss(16'h0101));
      drive(.t("R4 zero"), .sc(16'h0000), .ss(16'h0000));
      // R2 hardware set beats software clear on same bit
      drive(.t("R2 race"), .hw(16'h0010), .sc(16'h0011));
      // R3 software set beats software clear
      drive(.t("R3 race"), .ss(16'h0020), .sc(16'h0020));
      // R6 two sources share line 1
      drive(.t("R6"), .ew(4'b0110), .ed(16'h0F00 | 16'h00F0));
      drive(.t("R6 one"), .sc(16'h0030));
      drive(.t("R6 other"), .sc(16'h0100));
      // R8 clear while line still high re-arms next edge
      drive(.t("R8 rearm"), .ss(16'h0200), .ls(3'b010));
      drive(.t("R8 clr high"), .pc(3'b010));
      drive(.t("R8 back"));
      drive(.t("R8 ack"), .ak(3'b010));
      drive(.t("R8 ack back"));
      // R7 software pending set on a quiet line
      drive(.t("R7 sw"), .ps(3'b100));
      drive(.t("R10 off"));
      // R9 set and clear together: clear wins
      drive(.t("R9 race"), .ls(3'b100), .lc(3'b100));
      drive(.t("R9 on"), .ls(3'b100));
      drive(.t("R9 off"), .lc(3'b111));
      drive(.t("R8 sw clr"), .pc(3'b111), .sc(16'hFFFF));
      // R10 mixed traffic
      for (int i = 0; i < 300; i++) begin
         drive(.t("R10 mix"),
               .hw($urandom & $urandom), .ss($urandom & $urandom & $urandom),
               .sc($urandom), .ew(4'($urandom) & 4'($urandom)), .ed(16'($urandom)),
               .ps(3'($urandom) & 3'($urandom)), .pc(3'($urandom) & 3'($urandom)),
               .ak(3'($urandom) & 3'($urandom)), .ls(3'($urandom)),
               .lc(3'($urandom) & 3'($urandom)));
      end
      drive(.t("R10 end"));
      while (exp_q.size() > 0) @(posedge clk);
      #2;
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule